// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This controller counts nickels and dimes dropped through a single slot and opens the release chute once the credit reaches 15 cents. The coin sensor delivers one-cycle pulses, one line for nickels and one for dimes. The credit is kept in one of four named states:

| State | Credit | Code |
|-------|--------|------|
| `CR_0` | 0 cents | 00 |
| `CR_5` | 5 cents | 01 |
| `CR_10` | 10 cents | 10 |
| `CR_15` | 15 cents | 11 |

No change is given. Any payment above the price is absorbed, so the credit never goes past `CR_15`.

The transitions are as follows:

- **Idle hold:** with no coin pulse, the machine stays in its state.
- **Nickel step:** a nickel moves `CR_0`→`CR_5`, `CR_5`→`CR_10` and `CR_10`→`CR_15`.
- **Dime step:** a dime moves `CR_0`→`CR_10`, `CR_5`→`CR_15` and `CR_10`→`CR_15`. The last of these is the absorbed overpayment.
- **Full hold:** `CR_15` stays where it is whatever coins arrive.
- **Clear:** only the synchronous reset returns the machine to `CR_0`.

A pulse on both coin lines in the same cycle counts as a dime.

The `RETIMED` parameter picks how the open signal is produced.

- **`RETIMED=0`:** open is decoded from the state register.
- **`RETIMED=1`:** open has its own flip-flop, loaded from the next-state value. The output then carries no decode logic after the register.

The open signal has the same cycle timing in both forms.

Top module: `vend_ctrl`

## Requirements
- R1: With `rst` high at a clock edge the credit becomes `CR_0` and `open_o` is low after that edge; a coin pulse in the same cycle as reset is not counted.
- R2: A nickel pulse (`nickel_i`=1, `dime_i`=0) advances the credit by one step: `CR_0`→`CR_5`→`CR_10`→`CR_15`.
- R3: A dime pulse advances `CR_0`→`CR_10` and `CR_5`→`CR_15`.
- R4: A dime at `CR_10` goes to `CR_15`; the 5-cent overpayment is absorbed.
- R5: A cycle with neither coin line high leaves the credit unchanged.
- R6: A cycle with both coin lines high is counted as a dime.
- R7: `CR_15` holds, with `open_o` high, through any coin pulses until reset.
- R8: `open_o` is high exactly when the credit is `CR_15`. It rises after the clock edge that captures the completing coin and never earlier in the coin's own cycle.
- R9: With `RETIMED=1` the output comes from a flip-flop loaded with the next-state decode, and shows the same cycle timing as `RETIMED=0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| nickel_i | input | 1 | One-cycle pulse for a 5-cent coin |
| dime_i | input | 1 | One-cycle pulse for a 10-cent coin |
| open_o | output | 1 | Release chute open; high while 15 cents are held |

## Verification
A coin held high for the cycle between two falling edges is captured at the rising edge in between. Its effect on `open_o` is therefore due one cycle after it is driven, and the bench samples there, at the falling edge. The bench also samples just after driving a completing coin, before the edge, to confirm that the output does not react early. Intermediate credits are not visible at the ports. Each one is therefore checked by the cycle in which `open_o` later rises: after the right follow-up coin it must rise, and during idle cycles it must stay low. A Moore instance and a retimed instance run side by side on the same stimulus, and every check applies to both.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Credit held by the controller; the code is the stored state value.
    typedef enum logic [1:0] {
        CR_0  = 2'b00,
        CR_5  = 2'b01,
        CR_10 = 2'b10,
        CR_15 = 2'b11
    } credit_e;

    // Coin event seen in one cycle after sorting the two sensor lines.
    typedef enum logic [1:0] {
        COIN_NONE   = 2'b00,
        COIN_NICKEL = 2'b01,
        COIN_DIME   = 2'b10
    } coin_e;

endpackage

// File: rtl/vend_coin_sort.sv
module vend_coin_sort
    import vend_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_e coin_o
);

    // A dime pulse wins when both lines fire together.
    always_comb begin
        if (dime_i) begin
            coin_o = COIN_DIME;
        end else if (nickel_i) begin
            coin_o = COIN_NICKEL;
        end else begin
            coin_o = COIN_NONE;
        end
    end

endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  coin_e   coin_i,
    output credit_e state_q,
    output credit_e state_d
);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CR_0;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state function: saturating credit add
    always_comb begin
        state_d = state_q;
        unique case (coin_i)
            COIN_NICKEL: begin
                unique case (state_q)
                    CR_0:    state_d = CR_5;
                    CR_5:    state_d = CR_10;
                    CR_10:   state_d = CR_15;
                    CR_15:   state_d = CR_15;
                    default: state_d = CR_0;
                endcase
            end
            COIN_DIME: begin
                unique case (state_q)
                    CR_0:    state_d = CR_10;
                    CR_5:    state_d = CR_15;
                    CR_10:   state_d = CR_15;
                    CR_15:   state_d = CR_15;
                    default: state_d = CR_0;
                endcase
            end
            default: state_d = state_q;
        endcase
    end

endmodule

// File: rtl/vend_release.sv
module vend_release
    import vend_pkg::*;
#(
    parameter bit RETIMED = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  credit_e state_q,
    input  credit_e state_d,
    output logic    open_o
);

    generate
        if (RETIMED) begin : g_retimed
            // Output flip-flop loaded from the next-state decode
            logic open_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    open_q <= 1'b0;
                end else begin
                    open_q <= (state_d == CR_15);
                end
            end
            assign open_o = open_q;
            logic unused_moore;
            assign unused_moore = &{1'b0, state_q};
        end else begin : g_moore
            // Output decoded from the present state
            assign open_o = (state_q == CR_15);
            logic unused_retime;
            assign unused_retime = &{1'b0, clk, rst, state_d};
        end
    endgenerate

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter bit RETIMED = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic nickel_i,
    input  logic dime_i,
    output logic open_o
);

    coin_e   coin;
    credit_e state_q;
    credit_e state_d;

    vend_coin_sort u_sort (
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .coin_o   (coin)
    );

    vend_credit_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .coin_i  (coin),
        .state_q (state_q),
        .state_d (state_d)
    );

    vend_release #(.RETIMED(RETIMED)) u_rel (
        .clk     (clk),
        .rst     (rst),
        .state_q (state_q),
        .state_d (state_d),
        .open_o  (open_o)
    );

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
    import vend_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       nickel,
    input logic       dime,
    input logic       open_o,
    input logic [1:0] state
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (state == CR_0) && !open_o); // R1
    AST_NICKEL_STEP: assert property (@(posedge clk) disable iff (rst)
        (nickel && !dime && state == CR_0) |=> state == CR_5); // R2
    AST_DIME_STEP: assert property (@(posedge clk) disable iff (rst)
        (dime && state == CR_5) |=> state == CR_15); // R3
    AST_DIME_ABSORB: assert property (@(posedge clk) disable iff (rst)
        (dime && state == CR_10) |=> state == CR_15); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!nickel && !dime) |=> $stable(state)); // R5
    AST_BOTH_AS_DIME: assert property (@(posedge clk) disable iff (rst)
        (nickel && dime && state == CR_0) |=> state == CR_10); // R6
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == CR_15) |=> (state == CR_15) && open_o); // R7
    AST_OPEN_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        open_o |-> state == CR_15); // R8
    AST_OPEN_AFTER_COIN: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> $past(nickel || dime)); // R9

endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .nickel (nickel_i),
    .dime   (dime_i),
    .open_o (open_o),
    .state  (state_q)
);

// File: tb/vend_ctrl_test.sv
`timescale 1ns/1ps
module vend_ctrl_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic open_m;
    logic open_r;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    vend_ctrl #(.RETIMED(1'b0)) uut (
        .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .open_o(open_m)
    );
    vend_ctrl #(.RETIMED(1'b1)) uut_rt (
        .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .open_o(open_r)
    );

    task automatic check(input logic exp, input string req);
        n_checks++;
        if (open_m !== exp) begin
            n_fail++;
            $display("FAIL %s moore open_o=%b expected %b", req, open_m, exp);
        end
        n_checks++;
        if (open_r !== exp) begin
            n_fail++;
            $display("FAIL %s retimed open_o=%b expected %b", req, open_r, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive a one-cycle coin; sample at the following falling edge.
    task automatic coin(input logic n, input logic d);
        nickel = n;
        dime = d;
        @(negedge clk);
        nickel = 1'b0;
        dime = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(1'b0, "R1 reset state");
    endtask

    task automatic t_nickels();
        do_reset();
        coin(1, 0); check(1'b0, "R2 nickel 0->5");
        coin(1, 0); check(1'b0, "R2 nickel 5->10");
        coin(1, 0); check(1'b1, "R2 nickel 10->15");
    endtask

    task automatic t_dime_paths();
        do_reset();
        coin(1, 0); coin(0, 1); check(1'b1, "R3 dime 5->15");
        do_reset();
        coin(0, 1); check(1'b0, "R3 dime 0->10");
        coin(1, 0); check(1'b1, "R3 nickel after dime");
        do_reset();
        coin(0, 1); coin(0, 1); check(1'b1, "R4 dime at 10 absorbed");
    endtask

    task automatic t_idle_hold();
        do_reset();
        coin(1, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); check(1'b0, "R5 idle at 5");
        end
        coin(0, 1); check(1'b1, "R5 credit 5 kept");
        do_reset();
        coin(0, 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); check(1'b0, "R5 idle at 10");
        end
        coin(1, 0); check(1'b1, "R5 credit 10 kept");
    endtask

    task automatic t_both();
        do_reset();
        coin(1, 1); check(1'b0, "R6 both at 0");
        coin(1, 0); check(1'b1, "R6 both counted as dime");
        do_reset();
        coin(1, 0); coin(1, 1); check(1'b1, "R6 both at 5");
    endtask

    task automatic t_full_hold();
        do_reset();
        coin(0, 1); coin(0, 1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); check(1'b1, "R7 hold at 15");
        end
        coin(1, 0); check(1'b1, "R7 nickel at 15");
        coin(0, 1); check(1'b1, "R7 dime at 15");
        coin(1, 1); check(1'b1, "R7 both at 15");
    endtask

    task automatic t_reset_priority();
        do_reset();
        coin(0, 1); coin(0, 1);
        rst = 1'b1;
        coin(0, 1);
        rst = 1'b0;
        check(1'b0, "R1 reset from 15");
        coin(1, 0); coin(1, 0); check(1'b0, "R1 coin during reset not counted");
        coin(1, 0); check(1'b1, "R1 count restarted from 0");
    endtask

    task automatic t_timing();
        do_reset();
        coin(1, 0);
        dime = 1'b1;
        #1;
        check(1'b0, "R8 no open before edge");
        @(negedge clk);
        dime = 1'b0;
        check(1'b1, "R9 open one cycle after coin");
    endtask

    initial begin
        t_reset();
        t_nickels();
        t_dime_paths();
        t_idle_hold();
        t_both();
        t_full_hold();
        t_reset_priority();
        t_timing();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired open_o=%b expected completion", open_m);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule